// File: doc/BRIEF.md
# Execution State Register

This block holds the execution state of a processor core. It keeps a single instruction-set state bit and an eight-bit shared field. The shared field holds either the state of a conditional instruction block or the saved operand position of a multi-register load or store that an interrupt split, so that the transfer can resume. The block keeps a 32-bit image whose layout matches the processor's combined status word. The exception logic stacks this image and later restores it.

The register changes only through hardware paths:
- register branches and loads of the program counter that carry a state bit in the target address;
- exception entry, with the fetched vector;
- exception return, with the stacked status word;
- a debugger write port;
- save and resume strobes for the transfer index.

Software move-to and move-from status accesses reach the block. Reads return zero and writes are dropped. An issue strobe that arrives while the state bit is clear raises a one-cycle fault pulse.

Top module: `exec_state_reg`

## Requirements
- R1: While `rst_n` is low, the next clock edge loads `image_o` with bit 24 equal to `vector_lsb_i` and every other bit zero. After that edge `fault_o` is 0.
- R2: `sw_rdata_o` is all zeros in every cycle, whatever the register holds.
- R3: A cycle with `sw_wr_i` high and no other update strobe leaves `image_o` unchanged on the next cycle, for any `sw_wdata_i`.
- R4: A branch (`br_i`) that wins priority sets bit 24 to `br_lsb_i` on the next cycle and leaves all other bits unchanged.
- R5: An exception entry (`exc_entry_i`) that wins priority sets bit 24 to `vector_lsb_i` and leaves all other bits unchanged.
- R6: An exception return (`exc_ret_i`) that wins priority loads `image_o` with `stacked_i & 32'h0700_FC00`.
- R7: A debugger write (`dbg_wr_i`) sets bit 24 to `dbg_tbit_i` and leaves all other bits unchanged.
- R8: When several strobes arrive in one cycle, only the highest one acts. The order, highest first, is: reset, debugger write, exception entry, exception return, branch, index save, index resume.
- R9: An index save (`xfer_save_i`) that wins priority writes `xfer_idx_i` into bits [15:12] and clears bits [26:25] and [11:10]. Bit 24 is unchanged.
- R10: An index resume (`xfer_resume_i`) that wins priority clears bits [26:25] and [15:10] and keeps bit 24.
- R11: Bits [31:27], [23:16] and [9:0] of `image_o` are always zero.
- R12: `fault_o` is high in the cycle after an edge at which `issue_i` was high and bit 24 was 0, and low otherwise. A fault never alters `image_o`.
- R13: `tbit_o` equals bit 24 of `image_o`. `cond_o` equals `{image_o[15:10], image_o[26:25]}`. `xfer_idx_o` equals `image_o[15:12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | An instruction is issuing this cycle |
| br_i | input | 1 | Branch with state change |
| br_lsb_i | input | 1 | Bit 0 of the branch target |
| exc_entry_i | input | 1 | Exception entry |
| vector_lsb_i | input | 1 | Bit 0 of the fetched vector (entry and reset) |
| exc_ret_i | input | 1 | Exception return |
| stacked_i | input | 32 | Stacked status word being restored |
| dbg_wr_i | input | 1 | Debugger write of the state bit |
| dbg_tbit_i | input | 1 | State bit value from the debugger |
| xfer_save_i | input | 1 | Save the interrupted transfer position |
| xfer_idx_i | input | 4 | Next register operand of the transfer |
| xfer_resume_i | input | 1 | Transfer resumed; release the saved field |
| sw_wr_i | input | 1 | Software status write (dropped) |
| sw_wdata_i | input | 32 | Software write data (dropped) |
| sw_rdata_o | output | 32 | Software status read data (always zero) |
| image_o | output | 32 | Full register image for stacking |
| tbit_o | output | 1 | Instruction-set state bit |
| cond_o | output | 8 | Shared field in conditional-block order |
| xfer_idx_o | output | 4 | Saved transfer operand index |
| fault_o | output | 1 | Issue with state bit clear, one cycle late |

## Verification
The bench drives all strobes at once in random mixes. A wrong priority chain would let a branch or an index save override a debugger write or an exception path in the same cycle. Stacked words with random reserved bits are restored. A restore that does not mask them would show those bits in the image. Software writes are applied with data that differs from the register contents. Issue strobes are applied both while the state bit is clear and just after it is set. A fault computed from the next state instead of the current one would then fire or miss by one cycle. Reset is applied with each vector bit value.

// File: rtl/exec_state_reg.sv
module exec_state_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_i,
  input  logic        br_i,
  input  logic        br_lsb_i,
  input  logic        exc_entry_i,
  input  logic        vector_lsb_i,
  input  logic        exc_ret_i,
  input  logic [31:0] stacked_i,
  input  logic        dbg_wr_i,
  input  logic        dbg_tbit_i,
  input  logic        xfer_save_i,
  input  logic [3:0]  xfer_idx_i,
  input  logic        xfer_resume_i,
  input  logic        sw_wr_i,
  input  logic [31:0] sw_wdata_i,
  output logic [31:0] sw_rdata_o,
  output logic [31:0] image_o,
  output logic        tbit_o,
  output logic [7:0]  cond_o,
  output logic [3:0]  xfer_idx_o,
  output logic        fault_o
);
  localparam int          TB         = 24;
  localparam logic [31:0] FIELD_MASK = 32'h0600_FC00;
  localparam logic [31:0] LIVE_MASK  = FIELD_MASK | (32'h1 << TB);

  logic [31:0] img_q, img_d;

  always_comb begin
    img_d = img_q;
    if (dbg_wr_i)           img_d[TB] = dbg_tbit_i;
    else if (exc_entry_i)   img_d[TB] = vector_lsb_i;
    else if (exc_ret_i)     img_d = stacked_i & LIVE_MASK;
    else if (br_i)          img_d[TB] = br_lsb_i;
    else if (xfer_save_i)   img_d = (img_q & ~FIELD_MASK) | {16'h0, xfer_idx_i, 12'h0};
    else if (xfer_resume_i) img_d = img_q & ~FIELD_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q   <= {7'h0, vector_lsb_i, 24'h0};
      fault_o <= 1'b0;
    end else begin
      img_q   <= img_d;
      fault_o <= issue_i & ~img_q[TB];
    end
  end

  assign sw_rdata_o = '0;
  assign image_o    = img_q;
  assign tbit_o     = img_q[TB];
  assign cond_o     = {img_q[15:10], img_q[26:25]};
  assign xfer_idx_o = img_q[15:12];

  logic quiet;
  assign quiet = !(dbg_wr_i || exc_entry_i || exc_ret_i || br_i || xfer_save_i || xfer_resume_i);

  assert_sw_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_i && quiet && (sw_wdata_i != image_o) |=> $stable(image_o));

  assert_branch_sets_tbit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_i && !dbg_wr_i && !exc_entry_i && !exc_ret_i
      |=> tbit_o == $past(br_lsb_i) && cond_o == $past(cond_o));

  assert_entry_sets_tbit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry_i && !dbg_wr_i |=> tbit_o == $past(vector_lsb_i) && cond_o == $past(cond_o));

  assert_return_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ret_i && !dbg_wr_i && !exc_entry_i |=> image_o == ($past(stacked_i) & 32'h0700_FC00));

  assert_debug_sets_tbit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_wr_i |=> tbit_o == $past(dbg_tbit_i) && cond_o == $past(cond_o));

  assert_save_clears_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_save_i && !dbg_wr_i && !exc_entry_i && !exc_ret_i && !br_i
      |=> xfer_idx_o == $past(xfer_idx_i) && image_o[26:25] == 2'b00 && image_o[11:10] == 2'b00);

  assert_resume_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_resume_i && quiet == 1'b0 && !dbg_wr_i && !exc_entry_i && !exc_ret_i && !br_i && !xfer_save_i
      |=> cond_o == 8'h00 && $stable(tbit_o));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (image_o & 32'hF8FF_03FF) == 32'h0);

  assert_fault_raised_R12: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !tbit_o |=> fault_o);

  assert_fault_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_i && !tbit_o) |=> !fault_o);
endmodule

// File: tb/test_exec_state_reg.sv
module test_exec_state_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, issue_i, br_i, br_lsb_i, exc_entry_i, vector_lsb_i, exc_ret_i;
  logic [31:0] stacked_i, sw_wdata_i, sw_rdata_o, image_o;
  logic        dbg_wr_i, dbg_tbit_i, xfer_save_i, xfer_resume_i, sw_wr_i;
  logic [3:0]  xfer_idx_i, xfer_idx_o;
  logic [7:0]  cond_o;
  logic        tbit_o, fault_o;

  exec_state_reg i_exec_state_reg (.*);

  int vectors = 0, miscompares = 0;
  logic [31:0] exp_img;
  logic        exp_fault;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_img(logic [31:0] cur);
    logic [31:0] n = cur;
    if (!rst_n)              n = {7'h0, vector_lsb_i, 24'h0};
    else if (dbg_wr_i)       n[24] = dbg_tbit_i;
    else if (exc_entry_i)    n[24] = vector_lsb_i;
    else if (exc_ret_i)      n = stacked_i & 32'h0700_FC00;
    else if (br_i)           n[24] = br_lsb_i;
    else if (xfer_save_i)    n = {5'h0, 2'b00, cur[24], 8'h0, xfer_idx_i, 12'h0};
    else if (xfer_resume_i)  n = {7'h0, cur[24], 24'h0};
    return n;
  endfunction

  function automatic string tag_of();
    if (!rst_n)             return "R1";
    if (dbg_wr_i)           return (exc_entry_i || exc_ret_i || br_i) ? "R8" : "R7";
    if (exc_entry_i)        return (exc_ret_i || br_i) ? "R8" : "R5";
    if (exc_ret_i)          return br_i ? "R8" : "R6";
    if (br_i)               return (xfer_save_i || xfer_resume_i) ? "R8" : "R4";
    if (xfer_save_i)        return xfer_resume_i ? "R8" : "R9";
    if (xfer_resume_i)      return "R10";
    if (sw_wr_i)            return "R3";
    return "R11";
  endfunction

  task automatic idle();
    rst_n = 1; issue_i = 0; br_i = 0; br_lsb_i = 0; exc_entry_i = 0; vector_lsb_i = 0;
    exc_ret_i = 0; stacked_i = 0; dbg_wr_i = 0; dbg_tbit_i = 0; xfer_save_i = 0;
    xfer_idx_i = 0; xfer_resume_i = 0; sw_wr_i = 0; sw_wdata_i = 0;
  endtask

  task automatic step();
    string t = tag_of();
    logic [31:0] n = next_img(exp_img);
    exp_fault = rst_n && issue_i && !exp_img[24];
    exp_img = n;
    @(posedge clk);
    @(negedge clk);
    check(t, image_o, exp_img);
    check("R12", {31'h0, fault_o}, {31'h0, exp_fault});
    check("R2", sw_rdata_o, 32'h0);
    check("R13", {tbit_o, cond_o, xfer_idx_o},
          {exp_img[24], exp_img[15:10], exp_img[26:25], exp_img[15:12]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    exp_img = 0;
    idle();
    @(negedge clk);
    // R1: reset with both vector bit values
    rst_n = 0; vector_lsb_i = 0; issue_i = 1; step();
    rst_n = 0; vector_lsb_i = 1; step();
    idle(); step();
    // R6: restore with reserved bits set
    exc_ret_i = 1; stacked_i = 32'hFFFF_FFFF; step();
    idle(); exc_ret_i = 1; stacked_i = 32'hFEFF_FFFF; step();
    // R12: issue while state bit clear, then after setting it
    idle(); issue_i = 1; step();
    idle(); issue_i = 1; dbg_wr_i = 1; dbg_tbit_i = 1; step();
    idle(); issue_i = 1; step();
    // R3: software write with differing data
    idle(); sw_wr_i = 1; sw_wdata_i = 32'h0000_0000; step();
    idle(); sw_wr_i = 1; sw_wdata_i = 32'hFFFF_FFFF; step();
    // R9 then R10
    idle(); xfer_save_i = 1; xfer_idx_i = 4'hB; step();
    idle(); xfer_resume_i = 1; step();
    // R8: all strobes at once
    idle(); dbg_wr_i = 1; dbg_tbit_i = 0; exc_entry_i = 1; vector_lsb_i = 1; exc_ret_i = 1;
    stacked_i = 32'h0100_0000; br_i = 1; br_lsb_i = 1; xfer_save_i = 1; xfer_idx_i = 4'h7;
    xfer_resume_i = 1; sw_wr_i = 1; sw_wdata_i = 32'h0100_0000; step();
    idle(); step();

    for (int i = 0; i < 3000; i++) begin
      idle();
      rst_n        = ($urandom % 64) != 0;
      issue_i      = $urandom % 2;
      br_i         = ($urandom % 4) == 0;
      br_lsb_i     = $urandom % 2;
      exc_entry_i  = ($urandom % 6) == 0;
      vector_lsb_i = $urandom % 2;
      exc_ret_i    = ($urandom % 5) == 0;
      stacked_i    = $urandom;
      dbg_wr_i     = ($urandom % 8) == 0;
      dbg_tbit_i   = $urandom % 2;
      xfer_save_i  = ($urandom % 4) == 0;
      xfer_idx_i   = 4'($urandom);
      xfer_resume_i = ($urandom % 5) == 0;
      sw_wr_i      = ($urandom % 3) == 0;
      sw_wdata_i   = $urandom;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule